// File: doc/BRIEF.md
# Paired float-to-integer converter

This block takes one 64-bit operand that carries two IEEE-754 single-precision numbers and turns each of them into a signed 32-bit integer. The number in the upper half of the operand becomes the upper word of the result, and the number in the lower half becomes the lower word. Each half is rounded under a 2-bit rounding mode. Each half is checked for invalid cases on its own: infinity, NaN, or a rounded value outside the signed 32-bit range. A half that is invalid does not affect its neighbour.

A small decoder examines the instruction word presented with the issue strobe and starts a conversion only when the word matches the conversion encoding. The conversion is registered, so the result, the write strobe and the trap request appear one clock after issue. When the invalid trap is enabled and either half is invalid, nothing is written and a trap request pulses. When the trap is disabled, each invalid half yields 0x7FFFFFFF. Three sticky flags record invalid, inexact and overflow conditions. Only reset clears them.

The reset input is asynchronous, active low, and released through a two-stage synchroniser inside the block.

Top module: `paired_f2i_conv`

## Requirements
- R1: A conversion is accepted only when `issue_i` is high and `instr_i` has bits 31..26 = 010001, bits 25..21 = 10110, bits 20..16 = 00000 and bits 5..0 = 100100. An issue cycle that fails this decode, or a cycle with `issue_i` low, leaves `res_o`, `wr_en_o`, `trap_o` and all flags unchanged, with `wr_en_o` low.
- R2: Bits 63..32 of `src_i` convert into bits 63..32 of `res_o`, and bits 31..0 convert into bits 31..0. The two halves convert independently. Outputs update on the first rising clock edge after the accepted issue cycle.
- R3: The rounding mode `rmode_i` is encoded as follows: 0 = to nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward −infinity.
- R4: A half is invalid when its exponent is all ones (infinity or NaN) or when its rounded value lies outside −2^31..2^31−1. An input of exactly −2^31 (0xCF000000) is valid and gives 0x80000000 with no flag. Any invalid half sets `flag_inv_o`.
- R5: When `trap_en_i` is high and either half is invalid, `wr_en_o` stays low and `trap_o` pulses for one cycle. `res_o` keeps its previous value, and `wr_en_o` and `trap_o` are never high together.
- R6: When `trap_en_i` is low, each invalid half yields 0x7FFFFFFF whatever its sign, the other half yields its normal result, and `wr_en_o` pulses.
- R7: `flag_inex_o` is set when a valid half had a nonzero fraction. Invalid halves never set it. Zero converts to 0 exactly. A nonzero subnormal converts to 0, or to +1 / −1 under rounding toward +infinity / −infinity respectively when the sign agrees, and sets the inexact flag.
- R8: `flag_ovf_o` is set when a finite half rounds outside the 32-bit range. It is always accompanied by `flag_inv_o`.
- R9: The three flags are sticky: once set, each stays set until reset.
- R10: After reset, `res_o` is 0, `dst_idx_o` is 0, and `wr_en_o`, `trap_o` and all three flags are low.
- R11: `src_idx_o` combinationally carries `instr_i` bits 15..11. `dst_idx_o` registers `instr_i` bits 10..6 on each accepted issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction presented this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | Two packed single-precision operands |
| rmode_i | input | 2 | Rounding mode |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| src_idx_o | output | 5 | Source register index from the instruction |
| res_o | output | 64 | Two packed signed 32-bit results |
| dst_idx_o | output | 5 | Destination register index of the last accepted issue |
| wr_en_o | output | 1 | Result write strobe, one cycle |
| trap_o | output | 1 | Invalid-operation trap request, one cycle |
| flag_inv_o | output | 1 | Sticky invalid-operation flag |
| flag_inex_o | output | 1 | Sticky inexact flag |
| flag_ovf_o | output | 1 | Sticky overflow flag |

## Verification
An invalid half and an inexact half can occur in the same operation. So can an invalid half with the trap enabled and a valid neighbour. The bench therefore pairs infinity, NaN and out-of-range operands with fractional operands in the other half. It then checks that the valid half still converts and still sets inexact when the trap is off. With the trap on, it checks that `res_o` holds its old value while the invalid flag rises and the trap pulses instead of the write.

// File: rtl/pf2i_pkg.sv
package pf2i_pkg;

  localparam int FP_EXP_W  = 8;
  localparam int FP_MAN_W  = 23;
  localparam int FP_W      = FP_EXP_W + FP_MAN_W + 1;
  localparam int INT_W     = 32;
  localparam int LANES     = 2;
  localparam int REG_IDX_W = 5;
  localparam int INSTR_W   = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

endpackage

// File: rtl/pf2i_decode.sv
module pf2i_decode
  import pf2i_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr_i,
  output logic                 hit_o,
  output logic [REG_IDX_W-1:0] fs_o,
  output logic [REG_IDX_W-1:0] fd_o
);

  localparam logic [5:0] OP_MAJOR = 6'b010001;
  localparam logic [4:0] OP_FMT   = 5'b10110;
  localparam logic [4:0] OP_ZERO  = 5'b00000;
  localparam logic [5:0] OP_FUNC  = 6'b100100;

  always_comb begin
    hit_o = (instr_i[31:26] == OP_MAJOR) &&
            (instr_i[25:21] == OP_FMT)   &&
            (instr_i[20:16] == OP_ZERO)  &&
            (instr_i[5:0]   == OP_FUNC);
    fs_o  = instr_i[15:11];
    fd_o  = instr_i[10:6];
  end

endmodule

// File: rtl/pf2i_lane.sv
module pf2i_lane
  import pf2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  input  rmode_e               rmode_i,
  output logic [OUT_W-1:0]     word_o,
  output logic                 inv_o,
  output logic                 ovf_o,
  output logic                 inex_o
);

  localparam int SIG_W   = MAN_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int POINT   = BIAS + MAN_W;
  localparam int RSH_MAX = SIG_W + 2;
  localparam int WIDE_W  = SIG_W + RSH_MAX;
  localparam int LSH_MAX = OUT_W - SIG_W;
  localparam int MAG_W   = OUT_W + 1;
  localparam int SH_W    = EXP_W + 1;

  localparam logic [SH_W-1:0]  POINT_V   = SH_W'(POINT);
  localparam logic [SH_W-1:0]  RSH_MAX_V = SH_W'(RSH_MAX);
  localparam logic [SH_W-1:0]  LSH_MAX_V = SH_W'(LSH_MAX);
  localparam logic [MAG_W-1:0] NEG_LIM   = MAG_W'(1) << (OUT_W - 1);
  localparam logic [MAG_W-1:0] POS_LIM   = NEG_LIM - MAG_W'(1);
  localparam logic [OUT_W-1:0] DFLT      = {1'b0, {(OUT_W-1){1'b1}}};

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [SIG_W-1:0]  sig;
  logic              special;
  logic [SH_W-1:0]   ex_w;
  logic [SH_W-1:0]   lsh;
  logic [SH_W-1:0]   rsh;
  logic [WIDE_W-1:0] wide;
  logic [MAG_W-1:0]  mag;
  logic [MAG_W-1:0]  mag_r;
  logic [OUT_W-1:0]  mag_word;
  logic              big;
  logic              guard;
  logic              sticky;
  logic              inc;
  logic              oor;

  // field unpack
  always_comb begin
    sgn     = fp_i[EXP_W+MAN_W];
    ex      = fp_i[EXP_W+MAN_W-1:MAN_W];
    sig     = {(|ex), fp_i[MAN_W-1:0]};
    special = &ex;
  end

  // alignment: left shift for integral values, right shift with guard/sticky otherwise
  always_comb begin
    ex_w   = {1'b0, ex};
    lsh    = '0;
    rsh    = '0;
    wide   = '0;
    mag    = '0;
    big    = 1'b0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (ex_w >= POINT_V) begin
      lsh = ex_w - POINT_V;
      if (lsh > LSH_MAX_V) big = 1'b1;
      else                 mag = MAG_W'(sig) << lsh;
    end else begin
      rsh = POINT_V - ex_w;
      if (rsh > RSH_MAX_V) rsh = RSH_MAX_V;
      wide   = {sig, {RSH_MAX{1'b0}}} >> rsh;
      mag    = MAG_W'(wide[WIDE_W-1:RSH_MAX]);
      guard  = wide[RSH_MAX-1];
      sticky = |wide[RSH_MAX-2:0];
    end
  end

  // rounding increment per mode
  always_comb begin
    case (rmode_i)
      RM_NEAR: inc = guard & (sticky | mag[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sgn & (guard | sticky);
      RM_DOWN: inc = sgn & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  // range check and final word
  always_comb begin
    mag_r    = mag + MAG_W'(inc);
    oor      = big | (sgn ? (mag_r > NEG_LIM) : (mag_r > POS_LIM));
    inv_o    = special | oor;
    ovf_o    = ~special & oor;
    inex_o   = ~inv_o & (guard | sticky);
    mag_word = mag_r[OUT_W-1:0];
    if (inv_o)    word_o = DFLT;
    else if (sgn) word_o = ~mag_word + OUT_W'(1);
    else          word_o = mag_word;
  end

  // a valid non-negative input can never produce a negative word
  always_comb begin
    if (!inv_o && !sgn) begin
      AST_POS_KEEPS_SIGN: assert (!word_o[OUT_W-1]); // R2
    end
  end

endmodule

// File: rtl/paired_f2i_conv.sv
module paired_f2i_conv
  import pf2i_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_i,
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic [LANES*FP_W-1:0]  src_i,
  input  logic [1:0]             rmode_i,
  input  logic                   trap_en_i,
  output logic [REG_IDX_W-1:0]   src_idx_o,
  output logic [LANES*INT_W-1:0] res_o,
  output logic [REG_IDX_W-1:0]   dst_idx_o,
  output logic                   wr_en_o,
  output logic                   trap_o,
  output logic                   flag_inv_o,
  output logic                   flag_inex_o,
  output logic                   flag_ovf_o
);

  localparam int RES_W = LANES * INT_W;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  logic                 dec_hit;
  logic [REG_IDX_W-1:0] dec_fd;

  pf2i_decode u_dec (
    .instr_i (instr_i),
    .hit_o   (dec_hit),
    .fs_o    (src_idx_o),
    .fd_o    (dec_fd)
  );

  logic [RES_W-1:0] lane_word;
  logic [LANES-1:0] lane_inv, lane_ovf, lane_inex;
  rmode_e           rmode;

  assign rmode = rmode_e'(rmode_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pf2i_lane #(
      .EXP_W (FP_EXP_W),
      .MAN_W (FP_MAN_W),
      .OUT_W (INT_W)
    ) u_lane (
      .fp_i    (src_i[g*FP_W +: FP_W]),
      .rmode_i (rmode),
      .word_o  (lane_word[g*INT_W +: INT_W]),
      .inv_o   (lane_inv[g]),
      .ovf_o   (lane_ovf[g]),
      .inex_o  (lane_inex[g])
    );
  end

  // next-state logic
  logic                 accept, suppress;
  logic                 wr_d, trap_d, res_en;
  logic [RES_W-1:0]     res_d;
  logic [REG_IDX_W-1:0] dst_d;
  logic                 inv_d, inex_d, ovf_d;

  always_comb begin
    accept   = issue_i & dec_hit;
    suppress = trap_en_i & (|lane_inv);
    wr_d     = accept & ~suppress;
    trap_d   = accept & suppress;
    res_en   = wr_d;
    res_d    = lane_word;
    dst_d    = accept ? dec_fd : dst_idx_o;
    inv_d    = flag_inv_o  | (accept & (|lane_inv));
    inex_d   = flag_inex_o | (accept & (|lane_inex));
    ovf_d    = flag_ovf_o  | (accept & (|lane_ovf));
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_o       <= '0;
      dst_idx_o   <= '0;
      wr_en_o     <= 1'b0;
      trap_o      <= 1'b0;
      flag_inv_o  <= 1'b0;
      flag_inex_o <= 1'b0;
      flag_ovf_o  <= 1'b0;
    end else begin
      if (res_en) res_o <= res_d;
      dst_idx_o   <= dst_d;
      wr_en_o     <= wr_d;
      trap_o      <= trap_d;
      flag_inv_o  <= inv_d;
      flag_inex_o <= inex_d;
      flag_ovf_o  <= ovf_d;
    end
  end

  AST_WRITE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_en_o |-> $past(issue_i && dec_hit)); // R1

  AST_WE_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(wr_en_o && trap_o)); // R5

  AST_TRAP_HOLDS_RES: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_o |-> $stable(res_o)); // R5

  AST_OVF_WITH_INV: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_ovf_o |-> flag_inv_o); // R8

  AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_inv_o |=> flag_inv_o); // R9

  AST_INEX_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_inex_o |=> flag_inex_o); // R9

endmodule

// File: tb/paired_f2i_conv_test.sv
module paired_f2i_conv_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [31:0] instr_i;
  logic [63:0] src_i;
  logic [1:0]  rmode_i;
  logic        trap_en_i;
  logic [4:0]  src_idx_o;
  logic [63:0] res_o;
  logic [4:0]  dst_idx_o;
  logic        wr_en_o, trap_o, flag_inv_o, flag_inex_o, flag_ovf_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  paired_f2i_conv uut (
    .clk (clk), .rst_n (rst_n), .issue_i (issue_i), .instr_i (instr_i),
    .src_i (src_i), .rmode_i (rmode_i), .trap_en_i (trap_en_i),
    .src_idx_o (src_idx_o), .res_o (res_o), .dst_idx_o (dst_idx_o),
    .wr_en_o (wr_en_o), .trap_o (trap_o), .flag_inv_o (flag_inv_o),
    .flag_inex_o (flag_inex_o), .flag_ovf_o (flag_ovf_o)
  );

  localparam logic [31:0] INSTR_OK  = {6'b010001, 5'b10110, 5'b00000, 5'd3, 5'd7, 6'b100100};
  localparam logic [31:0] INSTR_BAD = {6'b010001, 5'b10000, 5'b00000, 5'd3, 5'd7, 6'b100100};

  // {src_hi, src_lo, rmode, exp_hi, exp_lo, {ovf, inex, inv}}
  localparam int NV = 14;
  localparam logic [132:0] VEC [NV] = '{
    {32'h3FC00000, 32'h40200000, 2'd0, 32'h00000002, 32'h00000002, 3'b010},
    {32'hC0200000, 32'h3F000000, 2'd0, 32'hFFFFFFFE, 32'h00000000, 3'b010},
    {32'h3FC00000, 32'hBFC00000, 2'd1, 32'h00000001, 32'hFFFFFFFF, 3'b010},
    {32'h3FA00000, 32'hBFA00000, 2'd2, 32'h00000002, 32'hFFFFFFFF, 3'b010},
    {32'h3FA00000, 32'hBFA00000, 2'd3, 32'h00000001, 32'hFFFFFFFE, 3'b010},
    {32'h40000000, 32'h4E6E6B28, 2'd0, 32'h00000002, 32'h3B9ACA00, 3'b000},
    {32'hCF000000, 32'h4EFFFFFF, 2'd0, 32'h80000000, 32'h7FFFFF80, 3'b000},
    {32'h7F800000, 32'h3FC00000, 2'd0, 32'h7FFFFFFF, 32'h00000002, 3'b011},
    {32'h40000000, 32'h7FC00000, 2'd1, 32'h00000002, 32'h7FFFFFFF, 3'b001},
    {32'h4F000000, 32'hFF800000, 2'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 3'b101},
    {32'h00000001, 32'h80000001, 2'd2, 32'h00000001, 32'h00000000, 3'b010},
    {32'h80000001, 32'h00000001, 2'd3, 32'hFFFFFFFF, 32'h00000000, 3'b010},
    {32'h80000000, 32'h00000000, 2'd0, 32'h00000000, 32'h00000000, 3'b000},
    {32'hCF000001, 32'h3F000000, 2'd2, 32'h7FFFFFFF, 32'h00000001, 3'b111}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    issue_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive for one cycle, sample at the following falling edge
  task automatic do_op(input logic iss, input logic [31:0] ins, input logic [63:0] src,
                       input logic [1:0] rm, input logic tr);
    issue_i = iss; instr_i = ins; src_i = src; rmode_i = rm; trap_en_i = tr;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; src_i = '0; rmode_i = '0; trap_en_i = 1'b0;
    do_reset();

    // R10 reset state
    chk("R10 res", res_o, 64'h0);
    chk("R10 ctl", {59'h0, wr_en_o, trap_o, flag_inv_o, flag_inex_o, flag_ovf_o}, 64'h0);
    chk("R10 dst", {59'h0, dst_idx_o}, 64'h0);

    // table walk: R2 R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      do_reset();
      do_op(1'b1, INSTR_OK, VEC[i][132:69], VEC[i][68:67], 1'b0);
      chk($sformatf("R2/R3 vec%0d result", i), res_o, VEC[i][66:3]);
      chk($sformatf("R6 vec%0d wr_en", i), {63'h0, wr_en_o}, 64'h1);
      chk($sformatf("R4/R7/R8 vec%0d flags", i),
          {61'h0, flag_ovf_o, flag_inex_o, flag_inv_o}, {61'h0, VEC[i][2:0]});
    end

    // R1 non-matching encoding and idle issue
    do_reset();
    do_op(1'b1, INSTR_BAD, 64'h7F800000_3FC00000, 2'd0, 1'b0);
    chk("R1 bad encoding", {res_o[31:0], 27'h0, wr_en_o, trap_o, flag_inv_o, flag_inex_o, flag_ovf_o}, 64'h0);
    do_op(1'b0, INSTR_OK, 64'h7F800000_3FC00000, 2'd0, 1'b1);
    chk("R1 issue low", {res_o[31:0], 27'h0, wr_en_o, trap_o, flag_inv_o, flag_inex_o, flag_ovf_o}, 64'h0);

    // R11 register indices
    instr_i = INSTR_OK;
    #1;
    chk("R11 src idx", {59'h0, src_idx_o}, 64'd3);
    do_op(1'b1, INSTR_OK, 64'h3FC00000_40000000, 2'd0, 1'b0);
    chk("R11 dst idx", {59'h0, dst_idx_o}, 64'd7);
    chk("R2 setup", res_o, 64'h00000002_00000002);

    // R5 trap: one lane invalid, write suppressed, result held
    do_op(1'b1, INSTR_OK, 64'h7F800000_3F800000, 2'd0, 1'b1);
    chk("R5 held result", res_o, 64'h00000002_00000002);
    chk("R5 strobes", {62'h0, wr_en_o, trap_o}, 64'b01);
    chk("R4 inv flag on trap", {63'h0, flag_inv_o}, 64'h1);
    @(negedge clk);
    chk("R5 trap one cycle", {63'h0, trap_o}, 64'h0);

    // R5 trap enabled but all valid: normal write; R9 flags stay set
    do_op(1'b1, INSTR_OK, 64'h40400000_40800000, 2'd0, 1'b1);
    chk("R5 valid with trap on", res_o, 64'h00000003_00000004);
    chk("R5 strobes valid", {62'h0, wr_en_o, trap_o}, 64'b10);
    chk("R9 sticky", {62'h0, flag_inv_o, flag_inex_o}, 64'b11);

    // R10 reset clears sticky state
    do_reset();
    chk("R10 flags cleared", {61'h0, flag_ovf_o, flag_inex_o, flag_inv_o}, 64'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule